// File: doc/BRIEF.md
# Wavelet QRS Beat Detector

The block watches a stream of 10-bit electrocardiogram samples and finds each QRS complex in it. Every accepted sample passes through a scale-3 quadratic spline wavelet detail filter. In that filter's output an R wave shows up as a positive maximum, then a zero crossing, then a negative minimum. The block pairs those two extrema and confirms the beat at the zero crossing between them. It then reports the interval from the previous beat, counted in samples.

The detection threshold follows the signal: it is recomputed from recent peak heights after every beat. A refractory interval and a pairing window keep out double counts and slow waves. An output word stream feeds a downstream transmitter. A two-bit mode input picks what goes into that stream: beat records, raw samples, or both interleaved. Each word carries a type flag.

Top module: `qrs_detector`

## Requirements
- R1: After reset, `beat`, `rr_valid`, `out_valid` and `rr_value` are all 0. The filter emits nothing until 15 samples have filled it, and a flat input produces no beat.
- R2: Each sufficiently large QRS-shaped pulse gives exactly one one-cycle `beat` pulse. The `rr_value` reported with a beat equals the distance, in samples, between the zero crossings of this beat and the previous one. For periodic pulses that distance is the pulse period.
- R3: The first beat after reset raises `beat` without `rr_valid`. Every later beat raises both together.
- R4: An extremum counts only if its magnitude is strictly above the threshold. After reset the threshold is `(INIT_PEAK*12)>>5`, so a pulse whose filter response stays below it is never reported.
- R5: On every beat the threshold becomes 3/8 of the mean of the last four accepted positive-maximum magnitudes, computed as `(3*sum)>>5`. Reset fills the history with `INIT_PEAK`.
- R6: A negative minimum pairs with the preceding positive maximum only if it comes at most `WIN` (36) samples later and a zero crossing lies between them. Otherwise the candidate is dropped and no beat results.
- R7: For `REFRACT` (60) samples after a beat, no new positive maximum can start a candidate.
- R8: The interval counter is `RR_W` (12) bits wide and saturates. An interval of 4095 samples or more is reported as 4095.
- R9: When `mode` is 1, the stream holds only beat records. A beat record is `out_data[12]=1` with the interval in `out_data[11:0]`, and there is one per beat that has `rr_valid`.
- R10: When `mode` is 2, the stream holds only raw words. A raw word is `out_data[12]=0` with the sample in `out_data[9:0]`, and there is one per input sample, in input order.
- R11: When `mode` is 3, raw words and beat records are interleaved. If both fall in the same cycle, the raw word goes first and the record follows one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Strobe, one cycle per new sample |
| sample_data | input | 10 | Unsigned ECG sample |
| mode | input | 2 | Stream mode: 1 records, 2 raw, 3 both, 0 none |
| beat | output | 1 | One-cycle pulse per confirmed beat |
| rr_valid | output | 1 | `rr_value` is new, raised with `beat` |
| rr_value | output | 12 | Beat-to-beat interval in samples, saturating |
| out_valid | output | 1 | `out_data` holds a stream word |
| out_data | output | 13 | Bit 12 type flag (1 record, 0 raw), low bits payload |

## Verification
The detector is driven with synthetic triangular pulses on a flat baseline. Tall narrow pulses at regular spacing check the beat count and the exact interval. Tiny pulses check that the initial threshold rejects them, while medium pulses check that the same threshold accepts them. A medium pulse placed after a run of tall ones is rejected, which separates an adaptive threshold from a fixed one. A slow wide pulse exceeds the pairing window. A pulse 40 samples after a beat falls inside the refractory time, and a gap of several thousand samples drives the interval counter into saturation. The same pulse train is then replayed in each stream mode to check the word types, their counts and their order.

// File: rtl/qrs_pkg.sv
package qrs_pkg;
  // scale-1 low-pass has LP_LEN taps; scale-2 copy is spread by 2
  localparam int LP_LEN = 4;
  localparam int SMOOTH_LEN = LP_LEN + 2 * (LP_LEN - 1);
  // scale-3 high-pass: two taps HP_GAP apart
  localparam int HP_GAP = 5;
  localparam int NTAPS = SMOOTH_LEN + HP_GAP;
  localparam int NPAIRS = NTAPS / 2;

  function automatic int lp_tap(int i);
    return (i == 0 || i == LP_LEN - 1) ? 1 : 3;
  endfunction

  // cascade of the scale-1 and dilated scale-2 low-pass filters
  function automatic int smooth_tap(int m);
    int s;
    s = 0;
    for (int i = 0; i < LP_LEN; i++)
      for (int j = 0; j < LP_LEN; j++)
        if (i + 2 * j == m) s += lp_tap(i) * lp_tap(j);
    return s;
  endfunction

  // equivalent scale-3 detail tap, antisymmetric about the centre
  function automatic int wav_coef(int k);
    return 2 * (smooth_tap(k) - smooth_tap(k - HP_GAP));
  endfunction

  typedef enum logic {PAIR_IDLE, PAIR_POS} pair_state_t;
  typedef enum logic {BEAT_ARMED, BEAT_HOLD} beat_state_t;
endpackage

// File: rtl/qrs_wavelet_fir.sv
module qrs_wavelet_fir import qrs_pkg::*; #(
  parameter int SAMPLE_W = 10,
  parameter int ACC_W = 20
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [SAMPLE_W-1:0]     in_data,
  output logic                    out_valid,
  output logic signed [ACC_W-1:0] out_data
);
  localparam int FILL_W = $clog2(NTAPS + 1);

  logic [SAMPLE_W-1:0] taps [NTAPS];
  logic [FILL_W-1:0] fill_cnt;
  logic stage_v;
  logic signed [ACC_W-1:0] prods [NPAIRS];
  logic signed [ACC_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NTAPS; k++) taps[k] <= '0;
      fill_cnt <= '0;
      stage_v <= 1'b0;
      out_valid <= 1'b0;
      out_data <= '0;
    end else begin
      stage_v <= in_valid && (fill_cnt >= FILL_W'(NTAPS - 1));
      if (in_valid) begin
        taps[0] <= in_data;
        for (int k = 1; k < NTAPS; k++) taps[k] <= taps[k-1];
        if (fill_cnt != FILL_W'(NTAPS)) fill_cnt <= fill_cnt + 1'b1;
      end
      out_valid <= stage_v;
      if (stage_v) out_data <= acc;
    end
  end

  // mirrored taps share one pre-subtractor (antisymmetric coefficients)
  for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
    localparam logic signed [7:0] CF = 8'(wav_coef(p));
    logic signed [SAMPLE_W:0] diff;
    assign diff = $signed({1'b0, taps[p]}) - $signed({1'b0, taps[NTAPS-1-p]});
    assign prods[p] = ACC_W'(diff) * ACC_W'(CF);
  end

  always_comb begin
    acc = '0;
    for (int p = 0; p < NPAIRS; p++) acc = acc + prods[p];
  end
endmodule

// File: rtl/qrs_feature.sv
module qrs_feature #(
  parameter int ACC_W = 20
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    y_valid,
  input  logic signed [ACC_W-1:0] y,
  output logic                    pos_max,
  output logic                    neg_min,
  output logic                    zero_x,
  output logic [ACC_W-1:0]        mag
);
  logic signed [ACC_W-1:0] y1, y2;
  logic [1:0] seen;
  logic ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      y1 <= '0;
      y2 <= '0;
      seen <= '0;
    end else if (y_valid) begin
      y1 <= y;
      y2 <= y1;
      if (seen != 2'd2) seen <= seen + 1'b1;
    end
  end

  assign ready = y_valid && (seen == 2'd2);
  // extrema are tested on the middle sample y1
  assign pos_max = ready && (y1 > y2) && (y <= y1) && (y1 > 0);
  assign neg_min = ready && (y1 < y2) && (y >= y1) && (y1 < 0);
  assign zero_x  = ready && (y1 > 0) && (y <= 0);
  assign mag = y1[ACC_W-1] ? ACC_W'(-y1) : ACC_W'(y1);
endmodule

// File: rtl/qrs_threshold.sv
module qrs_threshold #(
  parameter int ACC_W = 20,
  parameter int INIT_PEAK = 8000,
  parameter int HIST = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             update,
  input  logic [ACC_W-1:0] new_amp,
  output logic [ACC_W-1:0] thr
);
  localparam int SUM_W = ACC_W + $clog2(HIST) + 2;
  localparam int INIT_THR = (INIT_PEAK * HIST * 3) >> 5;

  logic [ACC_W-1:0] hist [HIST-1];
  logic [SUM_W-1:0] sum, scaled;

  always_comb begin
    sum = SUM_W'(new_amp);
    for (int k = 0; k < HIST - 1; k++) sum = sum + SUM_W'(hist[k]);
    scaled = (sum + (sum << 1)) >> 5;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < HIST - 1; k++) hist[k] <= ACC_W'(INIT_PEAK);
      thr <= ACC_W'(INIT_THR);
    end else if (update) begin
      hist[0] <= new_amp;
      for (int k = 1; k < HIST - 1; k++) hist[k] <= hist[k-1];
      thr <= ACC_W'(scaled);
    end
  end
endmodule

// File: rtl/qrs_decide.sv
module qrs_decide import qrs_pkg::*; #(
  parameter int ACC_W = 20,
  parameter int RR_W = 12,
  parameter int WIN = 36,
  parameter int REFRACT = 60
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             y_valid,
  input  logic             pos_max,
  input  logic             neg_min,
  input  logic             zero_x,
  input  logic [ACC_W-1:0] mag,
  input  logic [ACC_W-1:0] thr,
  output logic             amp_update,
  output logic [ACC_W-1:0] amp_value,
  output logic             beat,
  output logic             rr_valid,
  output logic [RR_W-1:0]  rr_value
);
  localparam int WIN_W = $clog2(WIN + 1);
  localparam int REF_W = $clog2(REFRACT + 1);
  localparam logic [RR_W-1:0] RR_MAX = '1;

  pair_state_t pstate;
  beat_state_t bstate;
  logic [WIN_W-1:0] win_cnt, zc_age;
  logic [REF_W-1:0] ref_cnt;
  logic [RR_W-1:0] rr_cnt;
  logic [ACC_W-1:0] pos_amp;
  logic zc_seen, have_prev, above, hold, pair_ok;

  assign above = mag > thr;
  assign hold = (bstate == BEAT_HOLD);
  assign pair_ok = y_valid && (pstate == PAIR_POS) && neg_min && above && zc_seen;
  assign amp_update = pair_ok && !hold;
  assign amp_value = pos_amp;

  // pairing FSM: positive maximum, zero crossing, negative minimum
  always_ff @(posedge clk) begin
    if (rst) begin
      pstate <= PAIR_IDLE;
      win_cnt <= '0;
      zc_age <= '0;
      pos_amp <= '0;
      zc_seen <= 1'b0;
    end else if (y_valid) begin
      if (zero_x) zc_age <= '0;
      else if (zc_age != WIN_W'(WIN)) zc_age <= zc_age + 1'b1;
      case (pstate)
        PAIR_IDLE: begin
          if (pos_max && above && !hold) begin
            pstate <= PAIR_POS;
            win_cnt <= '0;
            pos_amp <= mag;
            zc_seen <= 1'b0;
          end
        end
        default: begin
          if (zero_x) zc_seen <= 1'b1;
          if (pair_ok) begin
            pstate <= PAIR_IDLE;
          end else if (pos_max && above && !zc_seen && (mag > pos_amp)) begin
            win_cnt <= '0;
            pos_amp <= mag;
          end else if (win_cnt == WIN_W'(WIN - 1)) begin
            pstate <= PAIR_IDLE;
          end else begin
            win_cnt <= win_cnt + 1'b1;
          end
        end
      endcase
    end
  end

  // beat FSM: confirm, time stamp at the zero crossing, refractory hold
  always_ff @(posedge clk) begin
    if (rst) begin
      bstate <= BEAT_ARMED;
      ref_cnt <= '0;
      rr_cnt <= '0;
      have_prev <= 1'b0;
      beat <= 1'b0;
      rr_valid <= 1'b0;
      rr_value <= '0;
    end else begin
      beat <= 1'b0;
      rr_valid <= 1'b0;
      if (y_valid) begin
        if (rr_cnt != RR_MAX) rr_cnt <= rr_cnt + 1'b1;
        case (bstate)
          BEAT_ARMED: begin
            if (pair_ok) begin
              beat <= 1'b1;
              rr_valid <= have_prev;
              if (have_prev)
                rr_value <= (rr_cnt == RR_MAX) ? RR_MAX
                            : rr_cnt - RR_W'(zc_age) - 1'b1;
              have_prev <= 1'b1;
              rr_cnt <= RR_W'(zc_age) + RR_W'(2);
              ref_cnt <= '0;
              bstate <= BEAT_HOLD;
            end
          end
          default: begin
            if (ref_cnt == REF_W'(REFRACT - 1)) bstate <= BEAT_ARMED;
            else ref_cnt <= ref_cnt + 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/qrs_detector.sv
module qrs_detector #(
  parameter int SAMPLE_W = 10,
  parameter int ACC_W = 20,
  parameter int RR_W = 12,
  parameter int WIN = 36,
  parameter int REFRACT = 60,
  parameter int INIT_PEAK = 8000,
  parameter int DATA_W = 1 + ((RR_W > SAMPLE_W) ? RR_W : SAMPLE_W)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sample_valid,
  input  logic [SAMPLE_W-1:0] sample_data,
  input  logic [1:0]          mode,
  output logic                beat,
  output logic                rr_valid,
  output logic [RR_W-1:0]     rr_value,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_data
);
  logic y_valid;
  logic signed [ACC_W-1:0] y;
  logic pos_max, neg_min, zero_x, amp_update;
  logic [ACC_W-1:0] mag, thr, amp_value;
  logic raw_req, rec_req, pend;

  qrs_wavelet_fir #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_fir (
    .clk(clk), .rst(rst), .in_valid(sample_valid), .in_data(sample_data),
    .out_valid(y_valid), .out_data(y));

  qrs_feature #(.ACC_W(ACC_W)) u_feat (
    .clk(clk), .rst(rst), .y_valid(y_valid), .y(y),
    .pos_max(pos_max), .neg_min(neg_min), .zero_x(zero_x), .mag(mag));

  qrs_threshold #(.ACC_W(ACC_W), .INIT_PEAK(INIT_PEAK), .HIST(4)) u_thr (
    .clk(clk), .rst(rst), .update(amp_update), .new_amp(amp_value), .thr(thr));

  qrs_decide #(.ACC_W(ACC_W), .RR_W(RR_W), .WIN(WIN), .REFRACT(REFRACT)) u_dec (
    .clk(clk), .rst(rst), .y_valid(y_valid), .pos_max(pos_max),
    .neg_min(neg_min), .zero_x(zero_x), .mag(mag), .thr(thr),
    .amp_update(amp_update), .amp_value(amp_value),
    .beat(beat), .rr_valid(rr_valid), .rr_value(rr_value));

  // output stream: raw words win a tie, a record waits one slot
  assign raw_req = sample_valid && mode[1];
  assign rec_req = rr_valid && mode[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data <= '0;
      pend <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (raw_req) begin
        out_valid <= 1'b1;
        out_data <= {1'b0, (DATA_W-1)'(sample_data)};
        if (rec_req) pend <= 1'b1;
      end else if (rec_req || pend) begin
        out_valid <= 1'b1;
        out_data <= {1'b1, (DATA_W-1)'(rr_value)};
        pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/qrs_checker.sv
module qrs_checker #(
  parameter int RR_W = 12,
  parameter int REFRACT = 60,
  parameter int DATA_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              sample_valid,
  input logic [1:0]        mode,
  input logic              beat,
  input logic              rr_valid,
  input logic [RR_W-1:0]   rr_value,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);
  localparam int CNT_W = $clog2(REFRACT + 1);
  logic [CNT_W-1:0] since_beat;

  always_ff @(posedge clk) begin
    if (rst) since_beat <= CNT_W'(REFRACT);
    else if (beat) since_beat <= '0;
    else if (sample_valid && since_beat != CNT_W'(REFRACT)) since_beat <= since_beat + 1'b1;
  end

  assert_rr_with_beat_R3: assert property (@(posedge clk) disable iff (rst)
    rr_valid |-> beat);
  assert_beat_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    beat |=> !beat);
  assert_refractory_R7: assert property (@(posedge clk) disable iff (rst)
    beat |-> since_beat >= CNT_W'(REFRACT));
  assert_mode1_records_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(mode) == 2'd1) |-> out_data[DATA_W-1]);
  assert_mode2_raw_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(mode) == 2'd2 && $past(mode, 2) == 2'd2) |-> !out_data[DATA_W-1]);
  assert_rr_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    rr_valid |-> rr_value != '0);
endmodule

bind qrs_detector qrs_checker #(.RR_W(RR_W), .REFRACT(REFRACT), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .sample_valid(sample_valid), .mode(mode), .beat(beat),
  .rr_valid(rr_valid), .rr_value(rr_value), .out_valid(out_valid), .out_data(out_data));

// File: tb/qrs_detector_bench.sv
module qrs_detector_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_valid = 1'b0;
  logic [9:0] sample_data = '0;
  logic [1:0] mode = 2'd1;
  logic beat, rr_valid, out_valid;
  logic [11:0] rr_value;
  logic [12:0] out_data;

  int tests = 0;
  int fails = 0;
  int beat_cnt, rr_cnt, first_rr, rec_words, raw_words, raw_bad, rec_bad, last_sent, exp_rr;
  int rr_list [16];
  int sp_start [8];
  int sp_h [8];
  int sp_n, sp_hw;

  always #(CLK_PERIOD/2) clk = ~clk;

  qrs_detector #(.INIT_PEAK(4000)) u_qrs_detector (
    .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample_data(sample_data),
    .mode(mode), .beat(beat), .rr_valid(rr_valid), .rr_value(rr_value),
    .out_valid(out_valid), .out_data(out_data));

  always @(negedge clk) begin
    if (!rst) begin
      if (beat) begin
        if (beat_cnt == 0) first_rr = int'(rr_valid);
        beat_cnt++;
      end
      if (rr_valid) begin
        if (rr_cnt < 16) rr_list[rr_cnt] = int'(rr_value);
        rr_cnt++;
      end
      if (out_valid) begin
        if (out_data[12]) begin
          rec_words++;
          if (int'(out_data[11:0]) != exp_rr) rec_bad++;
        end else begin
          raw_words++;
          if (int'(out_data[9:0]) != last_sent) raw_bad++;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    rst = 1'b1;
    mode = m;
    beat_cnt = 0; rr_cnt = 0; first_rr = -1; rec_words = 0; raw_words = 0;
    raw_bad = 0; rec_bad = 0; last_sent = 0; sp_n = 0; sp_hw = 5; exp_rr = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic add_spike(input int start, input int h);
    sp_start[sp_n] = start;
    sp_h[sp_n] = h;
    sp_n++;
  endtask

  function automatic int shape(input int i);
    int r, d;
    for (int s = 0; s < sp_n; s++) begin
      r = i - sp_start[s];
      if (r >= 0 && r <= 2 * sp_hw) begin
        d = (r > sp_hw) ? r - sp_hw : sp_hw - r;
        return BASE + sp_h[s] * (sp_hw - d) / sp_hw;
      end
    end
    return BASE;
  endfunction

  task automatic feed(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sample_data = 10'(shape(i));
      last_sent = shape(i);
      sample_valid = 1'b1;
      @(negedge clk);
      sample_valid = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(2'd1);
    check(beat == 1'b0 && rr_valid == 1'b0 && out_valid == 1'b0, "R1 outputs after reset",
          int'(beat) + int'(rr_valid) + int'(out_valid), 0);
    check(rr_value == 12'd0, "R1 rr_value after reset", int'(rr_value), 0);
    feed(60);
    check(beat_cnt == 0, "R1 flat input gives no beat", beat_cnt, 0);
  endtask

  task automatic t_periodic;
    do_reset(2'd1);
    exp_rr = 150;
    for (int k = 0; k < 6; k++) add_spike(20 + 150 * k, 800);
    feed(830);
    check(beat_cnt == 6, "R2 beat count periodic", beat_cnt, 6);
    check(rr_cnt == 5, "R3 rr reports = beats-1", rr_cnt, 5);
    check(first_rr == 0, "R3 first beat has no rr", first_rr, 0);
    for (int k = 0; k < 5; k++)
      check(rr_list[k] == 150, "R2 rr equals period", rr_list[k], 150);
    check(rec_words == 5 && rec_bad == 0, "R9 mode 1 record words", rec_words, 5);
    check(raw_words == 0, "R9 mode 1 has no raw words", raw_words, 0);
  endtask

  task automatic t_mode3;
    do_reset(2'd3);
    exp_rr = 100;
    for (int k = 0; k < 5; k++) add_spike(20 + 100 * k, 700);
    feed(480);
    check(beat_cnt == 5, "R2 beat count period 100", beat_cnt, 5);
    check(raw_words == 480 && raw_bad == 0, "R11 mode 3 raw words in order", raw_words, 480);
    check(rec_words == 4 && rec_bad == 0, "R11 mode 3 record words", rec_words, 4);
  endtask

  task automatic t_mode2;
    do_reset(2'd2);
    exp_rr = 100;
    for (int k = 0; k < 5; k++) add_spike(20 + 100 * k, 700);
    feed(480);
    check(raw_words == 480 && raw_bad == 0, "R10 mode 2 raw words", raw_words, 480);
    check(rec_words == 0, "R10 mode 2 has no records", rec_words, 0);
    check(beat_cnt == 5, "R10 detection runs in mode 2", beat_cnt, 5);
  endtask

  task automatic t_refract;
    do_reset(2'd1);
    exp_rr = 150;
    add_spike(20, 800);
    add_spike(60, 800);
    add_spike(170, 800);
    feed(260);
    check(beat_cnt == 2, "R7 pulse inside refractory ignored", beat_cnt, 2);
    check(rr_list[0] == 150, "R7 rr skips ignored pulse", rr_list[0], 150);
  endtask

  task automatic t_small;
    do_reset(2'd1);
    for (int k = 0; k < 3; k++) add_spike(20 + 150 * k, 12);
    feed(400);
    check(beat_cnt == 0, "R4 pulses below threshold rejected", beat_cnt, 0);
    do_reset(2'd1);
    add_spike(20, 80);
    feed(100);
    check(beat_cnt == 1, "R4 medium pulse above initial threshold", beat_cnt, 1);
  endtask

  task automatic t_adapt;
    do_reset(2'd1);
    for (int k = 0; k < 5; k++) add_spike(20 + 150 * k, 800);
    add_spike(770, 80);
    feed(830);
    check(beat_cnt == 5, "R5 adapted threshold rejects medium pulse", beat_cnt, 5);
  endtask

  task automatic t_wide;
    do_reset(2'd1);
    sp_hw = 50;
    add_spike(20, 400);
    feed(200);
    check(beat_cnt == 0, "R6 extrema too far apart dropped", beat_cnt, 0);
  endtask

  task automatic t_sat;
    do_reset(2'd1);
    exp_rr = 4095;
    add_spike(20, 800);
    add_spike(4300, 800);
    feed(4360);
    check(beat_cnt == 2, "R8 beats around long gap", beat_cnt, 2);
    check(rr_cnt == 1 && rr_list[0] == 4095, "R8 rr saturates", rr_list[0], 4095);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset;
    t_periodic;
    t_mode3;
    t_mode2;
    t_refract;
    t_small;
    t_adapt;
    t_wide;
    t_sat;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule